// File: doc/BRIEF.md
# Unit serial-number inquiry responder

This block sits beside a mass-storage command engine and answers one specific SCSI request by itself: the inquiry for the unit serial-number vital-product page. It looks at each 6-byte command descriptor block it is offered. A serial-number request has opcode 12h, the vital-product-data bit (bit 0 of byte 1) set and page 80h in byte 2. For that request the block collects the 20-byte serial field of the attached drive's identify data as a byte stream. Every null (00h) and space (20h) character is dropped while the rest keep their order, and the survivors are counted.

The block then streams the response on a valid/ready byte port: a 4-byte header followed by the compacted serial string, with a last-byte flag. The page length in the header is the survivor count, so the whole field has to be filtered before the first byte goes out. Any other command, or any other inquiry page, gets a one-cycle "unhandled" strobe and no data, so the surrounding engine can deal with it.

Top module: `sn_inquiry_responder`

## Requirements
- R1: A command with byte 0 = 12h, bit 0 of byte 1 = 1 and byte 2 = 80h (byte k on cdb_bytes[8k+7:8k]) is accepted for serving: cdb_ready falls in the cycle after acceptance and unhandled stays low.
- R2: Any other accepted command raises unhandled for exactly one cycle, in the cycle after acceptance. It produces no response byte, and cdb_ready stays high.
- R3: Response bytes 4 onward are the input serial bytes with every 00h and 20h removed, in their original order.
- R4: Response byte 0 is {cfg_qualifier[2:0], cfg_devtype[4:0]}, byte 1 is 80h and byte 2 is 00h.
- R5: Response byte 3 equals the number of serial characters kept after filtering (0 to 20).
- R6: The number of response bytes sent is the smaller of command byte 4 (allocation length) and 4 plus the kept count. An allocation length of 0 sends nothing, and the block returns to idle.
- R7: out_last is high on the final response byte only.
- R8: While out_valid is high and out_ready is low, out_valid stays high and out_data and out_last hold their values.
- R9: id_ready is high only while the block is taking serial bytes. It falls after exactly 20 bytes have been accepted, and cdb_ready is high only when the block is idle with no response pending.
- R10: After reset, cdb_ready is high and out_valid, out_last, id_ready and unhandled are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cdb_valid | input | 1 | Command descriptor block offered |
| cdb_bytes | input | 48 | Command bytes, byte k on bits [8k+7:8k] |
| cdb_ready | output | 1 | Block is idle and takes a command |
| cfg_qualifier | input | 3 | Peripheral qualifier for response byte 0 |
| cfg_devtype | input | 5 | Device type code for response byte 0 |
| id_valid | input | 1 | Serial field byte offered |
| id_data | input | 8 | Serial field byte |
| id_ready | output | 1 | Block takes serial bytes |
| out_valid | output | 1 | Response byte valid |
| out_data | output | 8 | Response byte |
| out_last | output | 1 | Final response byte |
| out_ready | input | 1 | Receiver takes the response byte |
| unhandled | output | 1 | One-cycle strobe for a command not served here |

## Verification
The filter is driven with a space-separated serial padded with blanks, with nulls mixed among the characters, with an all-filler field and with a field that has no filler. These cases separate correct dropping and ordering from off-by-one counts at 0 and at 20. Allocation lengths of 255, 10, 2 and 0 show truncation inside the serial text, inside the header and to nothing. Runs with a pseudo-random stall on the output and gaps on the input check that holding and pacing do not lose or repeat bytes. Commands that miss on the opcode, on the vital-product-data bit or on the page code confirm that each of the three fields alone is enough to reject a command.

// File: rtl/sni_pkg.sv
package sni_pkg;
  localparam logic [7:0] OPC_INQUIRY = 8'h12;
  localparam logic [7:0] PAGE_SERIAL = 8'h80;
  localparam logic [7:0] FILL_NUL    = 8'h00;
  localparam logic [7:0] FILL_SPACE  = 8'h20;

  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_GATHER = 2'd1,
    ST_EMIT   = 2'd2
  } sni_state_e;
endpackage

// File: rtl/sni_cdb_decode.sv
module sni_cdb_decode
  import sni_pkg::*;
(
  input  logic [47:0] cdb_bytes,
  output logic        is_serial_req,
  output logic [7:0]  alloc_len
);
  logic [7:0] opc, flags, page;

  assign opc   = cdb_bytes[7:0];
  assign flags = cdb_bytes[15:8];
  assign page  = cdb_bytes[23:16];
  assign alloc_len = cdb_bytes[39:32];

  assign is_serial_req = (opc == OPC_INQUIRY) && flags[0] && (page == PAGE_SERIAL);
endmodule

// File: rtl/sni_compactor.sv
module sni_compactor
  import sni_pkg::*;
#(
  parameter int SER_LEN = 20,
  parameter int AW      = $clog2(SER_LEN),
  parameter int CW      = $clog2(SER_LEN + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          start,
  input  logic          in_valid,
  input  logic [7:0]    in_data,
  output logic          in_ready,
  output logic          done,
  output logic [CW-1:0] kept,
  input  logic [AW-1:0] rd_addr,
  output logic [7:0]    rd_data
);
  logic [7:0]    mem [SER_LEN];
  logic [CW-1:0] seen;
  logic          active;
  logic          take, keep_it;

  assign in_ready = active;
  assign take     = in_valid && active;
  assign keep_it  = (in_data != FILL_NUL) && (in_data != FILL_SPACE);

  // Storage has no reset so it can map onto RAM primitives.
  always_ff @(posedge clk) begin
    if (take && keep_it) mem[kept[AW-1:0]] <= in_data;
  end

  assign rd_data = mem[rd_addr];

  always_ff @(posedge clk) begin
    if (rst) begin
      active <= 1'b0;
      seen   <= '0;
      kept   <= '0;
      done   <= 1'b0;
    end else begin
      done <= 1'b0;
      if (start) begin
        active <= 1'b1;
        seen   <= '0;
        kept   <= '0;
      end else if (take) begin
        seen <= seen + 1'b1;
        if (keep_it) kept <= kept + 1'b1;
        if (seen == CW'(SER_LEN - 1)) begin
          active <= 1'b0;
          done   <= 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/sn_inquiry_responder.sv
module sn_inquiry_responder
  import sni_pkg::*;
#(
  parameter int SER_LEN = 20
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        cdb_valid,
  input  logic [47:0] cdb_bytes,
  output logic        cdb_ready,
  input  logic [2:0]  cfg_qualifier,
  input  logic [4:0]  cfg_devtype,
  input  logic        id_valid,
  input  logic [7:0]  id_data,
  output logic        id_ready,
  output logic        out_valid,
  output logic [7:0]  out_data,
  output logic        out_last,
  input  logic        out_ready,
  output logic        unhandled
);
  localparam int AW    = $clog2(SER_LEN);
  localparam int CW    = $clog2(SER_LEN + 1);
  localparam int HDR_N = 4;

  sni_state_e    state;
  logic          is_req, accept, start, done;
  logic [7:0]    alloc_in, alloc_q, ptr, total, full_len, next_byte;
  logic [CW-1:0] kept;
  logic [AW-1:0] rd_addr;
  logic [7:0]    rd_data;

  sni_cdb_decode u_dec (
    .cdb_bytes    (cdb_bytes),
    .is_serial_req(is_req),
    .alloc_len    (alloc_in)
  );

  sni_compactor #(.SER_LEN(SER_LEN), .AW(AW), .CW(CW)) u_cmp (
    .clk     (clk),
    .rst     (rst),
    .start   (start),
    .in_valid(id_valid),
    .in_data (id_data),
    .in_ready(id_ready),
    .done    (done),
    .kept    (kept),
    .rd_addr (rd_addr),
    .rd_data (rd_data)
  );

  assign cdb_ready = (state == ST_IDLE);
  assign accept    = cdb_valid && cdb_ready;
  assign start     = accept && is_req;

  assign full_len = 8'(kept) + 8'(HDR_N);
  assign total    = (alloc_q < full_len) ? alloc_q : full_len;
  assign rd_addr  = AW'(ptr - 8'(HDR_N));

  always_comb begin
    case (ptr)
      8'd0:    next_byte = {cfg_qualifier, cfg_devtype};
      8'd1:    next_byte = PAGE_SERIAL;
      8'd2:    next_byte = 8'h00;
      8'd3:    next_byte = 8'(kept);
      default: next_byte = rd_data;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= ST_IDLE;
      alloc_q   <= '0;
      ptr       <= '0;
      out_valid <= 1'b0;
      out_data  <= '0;
      out_last  <= 1'b0;
      unhandled <= 1'b0;
    end else begin
      unhandled <= accept && !is_req;
      case (state)
        ST_IDLE: begin
          if (start) begin
            alloc_q <= alloc_in;
            state   <= ST_GATHER;
          end
        end
        ST_GATHER: begin
          if (done) begin
            ptr   <= '0;
            state <= (alloc_q == 8'd0) ? ST_IDLE : ST_EMIT;
          end
        end
        ST_EMIT: begin
          if (!out_valid || out_ready) begin
            if (ptr < total) begin
              out_valid <= 1'b1;
              out_data  <= next_byte;
              out_last  <= (ptr == total - 8'd1);
              ptr       <= ptr + 8'd1;
            end else begin
              out_valid <= 1'b0;
              out_last  <= 1'b0;
              if (out_valid) state <= ST_IDLE;
            end
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/sni_checker.sv
module sni_checker (
  input logic       clk,
  input logic       rst,
  input logic       cdb_ready,
  input logic       id_ready,
  input logic       out_valid,
  input logic       out_ready,
  input logic [7:0] out_data,
  input logic       out_last,
  input logic       unhandled
);
  AST_STALL_HOLD: assert property (@(posedge clk) disable iff (rst)
    out_valid && !out_ready |=> out_valid && $stable(out_data) && $stable(out_last)); // R8

  AST_UNHANDLED_NO_DATA: assert property (@(posedge clk) disable iff (rst)
    unhandled |-> !out_valid && cdb_ready); // R2

  AST_LAST_NEEDS_VALID: assert property (@(posedge clk) disable iff (rst)
    out_last |-> out_valid); // R7

  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (rst)
    cdb_ready |-> !id_ready && !out_valid); // R9

  AST_NO_GATHER_WHILE_SEND: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> !id_ready); // R9
endmodule

bind sn_inquiry_responder sni_checker u_sni_chk (
  .clk      (clk),
  .rst      (rst),
  .cdb_ready(cdb_ready),
  .id_ready (id_ready),
  .out_valid(out_valid),
  .out_ready(out_ready),
  .out_data (out_data),
  .out_last (out_last),
  .unhandled(unhandled)
);

// File: tb/sn_inquiry_responder_test.sv
module sn_inquiry_responder_test;
  localparam int CLK_PERIOD = 10;
  localparam int SER_N = 20;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        cdb_valid = 1'b0;
  logic [47:0] cdb_bytes = '0;
  logic        cdb_ready;
  logic [2:0]  cfg_qualifier = 3'b000;
  logic [4:0]  cfg_devtype = 5'h00;
  logic        id_valid = 1'b0;
  logic [7:0]  id_data = '0;
  logic        id_ready;
  logic        out_valid;
  logic [7:0]  out_data;
  logic        out_last;
  logic        out_ready = 1'b1;
  logic        unhandled;

  int n_checks = 0;
  int n_fail = 0;
  int got_bytes = 0;
  int cyc = 0;
  bit bp_on = 0;
  logic [8:0] expq[$];
  logic [7:0] ser[SER_N];

  always #(CLK_PERIOD / 2) clk = ~clk;

  sn_inquiry_responder uut (
    .clk(clk), .rst(rst), .cdb_valid(cdb_valid), .cdb_bytes(cdb_bytes),
    .cdb_ready(cdb_ready), .cfg_qualifier(cfg_qualifier), .cfg_devtype(cfg_devtype),
    .id_valid(id_valid), .id_data(id_data), .id_ready(id_ready),
    .out_valid(out_valid), .out_data(out_data), .out_last(out_last),
    .out_ready(out_ready), .unhandled(unhandled)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      n_checks++; n_fail++;
      $display("FAIL watchdog: actual %0d expected %0d", cyc, 150000);
      finish_run();
    end
  end

  // Monitor: drives out_ready, then judges the transfer that the next edge will make.
  logic [7:0] lfsr = 8'hA5;
  bit         stalled = 0;
  logic [8:0] stall_val;
  always @(negedge clk) begin
    if (!rst) begin
      if (stalled)
        check(out_valid && {out_last, out_data} == stall_val, "R8 hold",
              int'({out_last, out_data}), int'(stall_val));
      lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
      out_ready = bp_on ? (lfsr[0] | lfsr[2]) : 1'b1;
      if (out_valid && out_ready) begin
        if (expq.size() == 0) begin
          check(0, "R6 extra byte", int'(out_data), 0);
        end else begin
          logic [8:0] e;
          e = expq.pop_front();
          if (out_last != e[8])
            check(0, "R7 last flag", int'(out_last), int'(e[8]));
          else if (got_bytes < 3)
            check(out_data == e[7:0], "R4 header", int'(out_data), int'(e[7:0]));
          else if (got_bytes == 3)
            check(out_data == e[7:0], "R5 length", int'(out_data), int'(e[7:0]));
          else
            check(out_data == e[7:0], "R3 serial", int'(out_data), int'(e[7:0]));
        end
        got_bytes++;
      end
      stalled = out_valid && !out_ready;
      stall_val = {out_last, out_data};
    end
  end

  task automatic set_serial(input string s, input logic [7:0] pad);
    for (int i = 0; i < SER_N; i++) ser[i] = (i < s.len()) ? 8'(s[i]) : pad;
  endtask

  task automatic serve(input logic [7:0] alloc, input bit bp, input int gap);
    logic [7:0] full[$];
    int cnt, total;
    cnt = 0;
    for (int i = 0; i < SER_N; i++) if (ser[i] != 8'h00 && ser[i] != 8'h20) cnt++;
    full.push_back({cfg_qualifier, cfg_devtype});
    full.push_back(8'h80);
    full.push_back(8'h00);
    full.push_back(8'(cnt));
    for (int i = 0; i < SER_N; i++) if (ser[i] != 8'h00 && ser[i] != 8'h20) full.push_back(ser[i]);
    total = (int'(alloc) < cnt + 4) ? int'(alloc) : cnt + 4;
    for (int i = 0; i < total; i++) expq.push_back({(i == total - 1), full[i]});
    got_bytes = 0;
    bp_on = bp;
    while (!cdb_ready) @(negedge clk);
    cdb_bytes = {8'h00, alloc, 8'h00, 8'h80, 8'h01, 8'h12};
    cdb_valid = 1'b1;
    @(negedge clk);
    cdb_valid = 1'b0;
    check(!cdb_ready && !unhandled, "R1 accepted", int'({cdb_ready, unhandled}), 0);
    for (int i = 0; i < SER_N; i++) begin
      id_valid = 1'b1;
      id_data = ser[i];
      while (!id_ready) @(negedge clk);
      @(negedge clk);
      id_valid = 1'b0;
      for (int g = 0; g < gap; g++) @(negedge clk);
    end
    check(!id_ready, "R9 id_ready after 20", int'(id_ready), 0);
    while (!(cdb_ready && expq.size() == 0)) @(negedge clk);
    repeat (3) @(negedge clk);
    check(got_bytes == total && expq.size() == 0, "R6 byte count", got_bytes, total);
  endtask

  task automatic reject(input logic [47:0] cmd);
    while (!cdb_ready) @(negedge clk);
    cdb_bytes = cmd;
    cdb_valid = 1'b1;
    got_bytes = 0;
    @(negedge clk);
    cdb_valid = 1'b0;
    check(unhandled && !out_valid && cdb_ready, "R2 strobe",
          int'({unhandled, out_valid, cdb_ready}), 3'b101);
    @(negedge clk);
    check(!unhandled, "R2 one cycle", int'(unhandled), 0);
    repeat (3) @(negedge clk);
    check(got_bytes == 0 && !id_ready, "R2 no data", got_bytes, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check(cdb_ready && !out_valid && !out_last && !id_ready && !unhandled, "R10 reset",
          int'({cdb_ready, out_valid, out_last, id_ready, unhandled}), 5'b10000);
    rst = 1'b0;
    @(negedge clk);

    set_serial("  713 740", 8'h20);
    serve(8'd255, 0, 0);

    cfg_qualifier = 3'b001; cfg_devtype = 5'h05;
    set_serial("A", 8'h00);
    ser[3] = "Q"; ser[7] = 8'h20; ser[8] = "z"; ser[19] = "9";
    serve(8'd255, 1, 1);

    set_serial("", 8'h00);
    ser[5] = 8'h20; ser[11] = 8'h20;
    serve(8'd64, 1, 0);

    cfg_qualifier = 3'b000; cfg_devtype = 5'h00;
    set_serial("ABCDEFGHIJKLMNOPQRST", 8'h20);
    serve(8'd24, 1, 0);

    set_serial("WD-XY 12 34 56", 8'h20);
    serve(8'd10, 1, 2);
    serve(8'd2, 0, 0);
    serve(8'd0, 0, 0);

    reject({8'h00, 8'hFF, 8'h00, 8'h80, 8'h01, 8'h1A});
    reject({8'h00, 8'hFF, 8'h00, 8'h80, 8'h00, 8'h12});
    reject({8'h00, 8'hFF, 8'h00, 8'h83, 8'h01, 8'h12});

    set_serial("S/N 0042", 8'h00);
    serve(8'd255, 1, 0);

    finish_run();
  end
endmodule